// File: doc/BRIEF.md
# Audio CPU I/O Page Decoder

This block sits between a small audio processor's 16-bit-address, 8-bit-data bus and its 64 KB working RAM. Most accesses pass straight through to the RAM port. Sixteen addresses at 00F0h–00FFh form a register page. That page holds a combined control register, an index/data pair that reaches the sound DSP's register file indirectly, four byte-wide mailbox ports towards the host, and the period and counter registers of three timers. The timer logic and the DSP live outside the block. The decoder turns bus cycles into enables, strobes and DSP requests for them.

The top 64 bytes of the address space, FFC0h–FFFFh, are served inside the block. A boot ROM, filled through a load stream before the processor runs, can be laid over that region. A shadow RAM always takes the processor's writes there. One control bit chooses which of the two the processor reads back.

Every read returns its data one cycle after the request, with a valid flag. Both input streams have no back-pressure. A beat on the host mailbox stream or the ROM load stream is taken in the cycle where its valid is high, so these interfaces have no ready signal.

Top module: `apu_io_page`

## Requirements
- R1: After reset the timer enables are 0, the host output bytes are 0, the four mailbox input bytes read as 0, and the boot ROM overlay is selected.
- R2: Accesses outside 00F0h–00FFh and outside FFC0h–FFFFh, and also those to 00F8h and 00F9h, appear unchanged on the RAM port (request, write flag, address, data). A read returns the RAM's data.
- R3: A write to the control register at 00F1h sets the timer enables from bits 2:0 of the written byte. Bit n enables timer n.
- R4: A control write with bit 4 set clears mailbox inputs 0 and 1 (00F4h, 00F5h). Bit 5 clears inputs 2 and 3 (00F6h, 00F7h). A clear wins over a host beat that arrives in the same cycle.
- R5: Bit 7 of a control write selects the overlay. When it is 1, reads of FFC0h–FFFFh return boot ROM bytes. When it is 0, they return shadow RAM bytes.
- R6: Writes to FFC0h–FFFFh always update the shadow RAM, whatever the overlay setting, and never reach the RAM port.
- R7: 00F2h holds the DSP index and reads back as written. A read of 00F3h issues a DSP read of index bits 6:0 and returns the DSP's reply.
- R8: A write to 00F3h issues a DSP write only when the stored index is below 128 (bit 7 clear). Otherwise no request appears.
- R9: A write to 00FAh+n (n = 0..2) pulses period strobe n with the written byte. A read of 00FDh+n returns timer n's 4-bit count, zero-extended, and pulses count-read strobe n. A write there pulses only clear strobe n. At most one such strobe or DSP request is active at a time. 00F0h, 00F1h and 00FAh–00FCh read as 0.
- R10: A write to 00F0h has no effect. It produces no RAM request, no strobe, and no change to timer enables, overlay or host bytes.
- R11: A write to 00F4h+p sets host output byte p (bits 8p+7:8p) and leaves the other bytes unchanged. A read of 00F4h+p returns mailbox input p as last loaded by the host stream, not the value written.
- R12: A beat on the ROM load stream writes the byte into boot ROM location `rom_ld_addr`, which is read at FFC0h plus that offset.
- R13: `cpu_rvalid` is high in the cycle after each read request, and `cpu_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor bus address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write request (wins over read) |
| cpu_rd | input | 1 | Read request |
| cpu_rdata | output | 8 | Read data, one cycle after the request |
| cpu_rvalid | output | 1 | Read data valid |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write flag |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the request |
| dsp_rd | output | 1 | DSP register read request |
| dsp_wr | output | 1 | DSP register write request |
| dsp_addr | output | 7 | DSP register index |
| dsp_wdata | output | 8 | DSP write data |
| dsp_rdata | input | 8 | DSP read reply, one cycle after the request |
| tmr_en | output | 3 | Timer enables |
| tmr_per_wr | output | 3 | Period write strobe per timer |
| tmr_per_data | output | 8 | Period value |
| tmr_cnt_rd | output | 3 | Count read strobe per timer |
| tmr_cnt_clr | output | 3 | Count clear strobe per timer |
| tmr_cnt | input | 12 | 4-bit counts, timer n at bits 4n+3:4n |
| host_in_valid | input | 1 | Mailbox input beat valid (always taken) |
| host_in_idx | input | 2 | Mailbox input port number |
| host_in_data | input | 8 | Mailbox input byte |
| host_out | output | 32 | Host output bytes, port p at bits 8p+7:8p |
| rom_ld_valid | input | 1 | Boot ROM load beat valid (always taken) |
| rom_ld_addr | input | 6 | Boot ROM load offset |
| rom_ld_data | input | 8 | Boot ROM load byte |

## Verification
The case hardest to reach from the ports is the set of side effects a single control write has on state the processor cannot read back directly: mailbox latches, timer enables and the overlay select. The stimulus sweeps all 256 control values. Before each one it refills the four mailbox latches with nonzero bytes through the host stream. After it, it reads the mailboxes and one ROM-region byte whose shadow and ROM contents differ. The other hard case is a clear that coincides with a host beat. It is reached by driving both in one cycle.

// File: rtl/apu_io_pkg.sv
package apu_io_pkg;
  localparam int DATA_W = 8;
  localparam int N_TMR  = 3;
  localparam int N_PORT = 4;

  // register page offsets (behaviour depends on them)
  localparam logic [3:0] OFF_TEST = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h1;
  localparam logic [3:0] OFF_IDX  = 4'h2;
  localparam logic [3:0] OFF_DSP  = 4'h3;
  localparam logic [3:0] OFF_PORT = 4'h4;
  localparam logic [3:0] OFF_PER  = 4'hA;
  localparam logic [3:0] OFF_CNT  = 4'hD;

  // control byte fields
  localparam int CB_CLR_LO = 4;
  localparam int CB_CLR_HI = 5;
  localparam int CB_ROM    = 7;

  typedef enum logic [1:0] {RG_EXT, RG_IO, RG_ROM} region_e;
  typedef enum logic [1:0] {SRC_EXT, SRC_DSP, SRC_LOC} rsrc_e;
endpackage

// File: rtl/apu_io_decode.sv
module apu_io_decode
  import apu_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [3:0]        io_off
);
  localparam logic [ADDR_W-5:0] IO_TAG = (ADDR_W-4)'(4'hF);

  always_comb begin
    io_off = addr[3:0];
    if (&addr[ADDR_W-1:ROM_AW])
      region = RG_ROM;
    else if (addr[ADDR_W-1:4] == IO_TAG && io_off != 4'h8 && io_off != 4'h9)
      region = RG_IO;
    else
      region = RG_EXT;
  end
endmodule

// File: rtl/apu_io_ctrl.sv
module apu_io_ctrl
  import apu_io_pkg::*;
#(
  parameter int DSP_AW = 7,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    rd,
  input  logic                    sel,
  input  logic [3:0]              off,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    hin_valid,
  input  logic [1:0]              hin_idx,
  input  logic [DATA_W-1:0]       hin_data,
  input  logic [N_TMR*CNT_W-1:0]  tmr_cnt,
  output logic                    rom_en,
  output logic [N_TMR-1:0]        tmr_en,
  output logic [N_TMR-1:0]        tmr_per_wr,
  output logic [DATA_W-1:0]       tmr_per_data,
  output logic [N_TMR-1:0]        tmr_cnt_rd,
  output logic [N_TMR-1:0]        tmr_cnt_clr,
  output logic                    dsp_rd,
  output logic                    dsp_wr,
  output logic [DSP_AW-1:0]       dsp_addr,
  output logic [DATA_W-1:0]       dsp_wdata,
  output logic [N_PORT*DATA_W-1:0] host_out,
  output logic [DATA_W-1:0]       io_rdata,
  output logic                    io_dsp
);
  logic              wr_io, rd_io, ctrl_wr, clr_lo, clr_hi;
  logic [DATA_W-1:0] idx_q;
  logic [N_TMR-1:0]  ten_q;
  logic              rom_q;
  logic [DATA_W-1:0] pin_q [N_PORT];

  assign wr_io   = wr && sel;
  assign rd_io   = rd && !wr && sel;
  assign ctrl_wr = wr_io && off == OFF_CTRL;
  assign clr_lo  = ctrl_wr && wdata[CB_CLR_LO];
  assign clr_hi  = ctrl_wr && wdata[CB_CLR_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q <= '0;
      rom_q <= 1'b1;
      idx_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ten_q <= wdata[N_TMR-1:0];
        rom_q <= wdata[CB_ROM];
      end
      if (wr_io && off == OFF_IDX) idx_q <= wdata;
    end
  end

  assign rom_en = rom_q;
  assign tmr_en = ten_q;

  // mailbox input latches and host output bytes
  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    logic clr_p;
    assign clr_p = (p < N_PORT/2) ? clr_lo : clr_hi;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_q[p] <= '0;
        host_out[p*DATA_W +: DATA_W] <= '0;
      end else begin
        if (clr_p)
          pin_q[p] <= '0;
        else if (hin_valid && hin_idx == 2'(p))
          pin_q[p] <= hin_data;
        if (wr_io && off == OFF_PORT + 4'(p))
          host_out[p*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  // timer strobes
  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign tmr_per_wr[t]  = wr_io && off == OFF_PER + 4'(t);
    assign tmr_cnt_clr[t] = wr_io && off == OFF_CNT + 4'(t);
    assign tmr_cnt_rd[t]  = rd_io && off == OFF_CNT + 4'(t);
  end
  assign tmr_per_data = wdata;

  // indirect DSP access
  assign dsp_addr  = idx_q[DSP_AW-1:0];
  assign dsp_wdata = wdata;
  assign dsp_wr    = wr_io && off == OFF_DSP && !idx_q[DATA_W-1];
  assign dsp_rd    = rd_io && off == OFF_DSP;
  assign io_dsp    = off == OFF_DSP;

  always_comb begin
    io_rdata = '0;
    case (off)
      OFF_IDX:        io_rdata = idx_q;
      4'h4:           io_rdata = pin_q[0];
      4'h5:           io_rdata = pin_q[1];
      4'h6:           io_rdata = pin_q[2];
      4'h7:           io_rdata = pin_q[3];
      OFF_CNT:        io_rdata = DATA_W'(tmr_cnt[0*CNT_W +: CNT_W]);
      OFF_CNT + 4'd1: io_rdata = DATA_W'(tmr_cnt[1*CNT_W +: CNT_W]);
      OFF_CNT + 4'd2: io_rdata = DATA_W'(tmr_cnt[2*CNT_W +: CNT_W]);
      default:        io_rdata = '0;
    endcase
  end

  AST_CLR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo |=> (pin_q[0] == '0 && pin_q[1] == '0)); // R4
  AST_CLR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hi |=> (pin_q[2] == '0 && pin_q[3] == '0)); // R4
  AST_TEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> tmr_en == $past(wdata[N_TMR-1:0])); // R3
  AST_DSP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_io && off == OFF_DSP && idx_q[DATA_W-1]) |-> !dsp_wr); // R8
endmodule

// File: rtl/apu_rom_overlay.sv
module apu_rom_overlay
  import apu_io_pkg::*;
#(
  parameter int ROM_AW = 6
) (
  input  logic              clk,
  input  logic              ld_valid,
  input  logic [ROM_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr,
  input  logic [ROM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rom_en,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [DATA_W-1:0] rom_mem [DEPTH];
  logic [DATA_W-1:0] shd_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_valid) rom_mem[ld_addr] <= ld_data;
    if (wr)       shd_mem[addr]    <= wdata;
  end

  assign rdata = rom_en ? rom_mem[addr] : shd_mem[addr];
endmodule

// File: rtl/apu_io_page.sv
module apu_io_page
  import apu_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 6,
  parameter int DSP_AW = 7,
  parameter int CNT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [7:0]                cpu_wdata,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  output logic [7:0]                cpu_rdata,
  output logic                      cpu_rvalid,
  output logic                      ram_req,
  output logic                      ram_we,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [7:0]                ram_wdata,
  input  logic [7:0]                ram_rdata,
  output logic                      dsp_rd,
  output logic                      dsp_wr,
  output logic [DSP_AW-1:0]         dsp_addr,
  output logic [7:0]                dsp_wdata,
  input  logic [7:0]                dsp_rdata,
  output logic [2:0]                tmr_en,
  output logic [2:0]                tmr_per_wr,
  output logic [7:0]                tmr_per_data,
  output logic [2:0]                tmr_cnt_rd,
  output logic [2:0]                tmr_cnt_clr,
  input  logic [3*CNT_W-1:0]        tmr_cnt,
  input  logic                      host_in_valid,
  input  logic [1:0]                host_in_idx,
  input  logic [7:0]                host_in_data,
  output logic [31:0]               host_out,
  input  logic                      rom_ld_valid,
  input  logic [ROM_AW-1:0]         rom_ld_addr,
  input  logic [7:0]                rom_ld_data
);
  region_e           region;
  logic [3:0]        io_off;
  logic [DATA_W-1:0] io_rdata, rom_rdata, loc_q;
  logic              io_dsp, rom_en, rd_go;
  logic              rvalid_q;
  rsrc_e             src_q;

  apu_io_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) i_dec (
    .addr(cpu_addr), .region(region), .io_off(io_off));

  apu_io_ctrl #(.DSP_AW(DSP_AW), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .rd(cpu_rd),
    .sel(region == RG_IO), .off(io_off), .wdata(cpu_wdata),
    .hin_valid(host_in_valid), .hin_idx(host_in_idx), .hin_data(host_in_data),
    .tmr_cnt(tmr_cnt), .rom_en(rom_en), .tmr_en(tmr_en),
    .tmr_per_wr(tmr_per_wr), .tmr_per_data(tmr_per_data),
    .tmr_cnt_rd(tmr_cnt_rd), .tmr_cnt_clr(tmr_cnt_clr),
    .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
    .host_out(host_out), .io_rdata(io_rdata), .io_dsp(io_dsp));

  apu_rom_overlay #(.ROM_AW(ROM_AW)) i_rom (
    .clk(clk), .ld_valid(rom_ld_valid), .ld_addr(rom_ld_addr), .ld_data(rom_ld_data),
    .wr(cpu_wr && region == RG_ROM), .addr(cpu_addr[ROM_AW-1:0]),
    .wdata(cpu_wdata), .rom_en(rom_en), .rdata(rom_rdata));

  // pass-through to RAM
  assign ram_req   = (cpu_wr || cpu_rd) && region == RG_EXT;
  assign ram_we    = cpu_wr;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;

  // one-cycle read return
  assign rd_go = cpu_rd && !cpu_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_LOC;
      loc_q    <= '0;
    end else begin
      rvalid_q <= rd_go;
      if (rd_go) begin
        if (region == RG_EXT)           src_q <= SRC_EXT;
        else if (region == RG_IO && io_dsp) src_q <= SRC_DSP;
        else                            src_q <= SRC_LOC;
        loc_q <= (region == RG_ROM) ? rom_rdata : io_rdata;
      end
    end
  end

  assign cpu_rvalid = rvalid_q;
  always_comb begin
    case (src_q)
      SRC_EXT: cpu_rdata = ram_rdata;
      SRC_DSP: cpu_rdata = dsp_rdata;
      default: cpu_rdata = loc_q;
    endcase
  end

  AST_ROM_NOT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_wr || cpu_rd) && (&cpu_addr[ADDR_W-1:ROM_AW])) |-> !ram_req); // R6
  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> cpu_rvalid); // R13
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_per_wr, tmr_cnt_rd, tmr_cnt_clr, dsp_rd, dsp_wr})); // R9
  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == ADDR_W'(16'h00F0)) |->
      (!ram_req && !dsp_wr && tmr_per_wr == '0 && tmr_cnt_clr == '0)); // R10
endmodule

// File: tb/test_apu_io_page.sv
`timescale 1ns/1ps
module test_apu_io_page;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        ram_req, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        dsp_rd, dsp_wr;
  logic [6:0]  dsp_addr;
  logic [7:0]  dsp_wdata;
  logic [7:0]  dsp_rdata = '0;
  logic [2:0]  tmr_en, tmr_per_wr, tmr_cnt_rd, tmr_cnt_clr;
  logic [7:0]  tmr_per_data;
  logic [11:0] tmr_cnt = 12'hC59;
  logic        host_in_valid = 1'b0;
  logic [1:0]  host_in_idx = '0;
  logic [7:0]  host_in_data = '0;
  logic [31:0] host_out;
  logic        rom_ld_valid = 1'b0;
  logic [5:0]  rom_ld_addr = '0;
  logic [7:0]  rom_ld_data = '0;

  int nchk = 0, nerr = 0;

  // snapshot of combinational outputs during an access
  logic       s_req, s_we, s_dwr, s_drd;
  logic [15:0] s_addr;
  logic [7:0] s_wd, s_pdata, s_dwd;
  logic [6:0] s_da;
  logic [2:0] s_per, s_crd, s_clr;
  logic       s_rv;

  always #5 clk = ~clk;

  apu_io_page i_apu_io_page (.*);

  function automatic logic [7:0] rom_val(int i);   return 8'(i*7 + 3); endfunction
  function automatic logic [7:0] shd_val(int i);   return 8'(i*13 + 65); endfunction
  function automatic logic [7:0] ext_val(logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'h3C; endfunction
  function automatic logic [7:0] dsp_val(logic [6:0] a);  return {1'b0, a} ^ 8'hA5; endfunction

  always @(posedge clk) begin
    if (ram_req && !ram_we) ram_rdata <= ext_val(ram_addr);
    if (dsp_rd) dsp_rdata <= dsp_val(dsp_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_req = ram_req; s_we = ram_we; s_addr = ram_addr; s_wd = ram_wdata;
    s_dwr = dsp_wr; s_drd = dsp_rd; s_da = dsp_addr; s_dwd = dsp_wdata;
    s_per = tmr_per_wr; s_pdata = tmr_per_data; s_crd = tmr_cnt_rd; s_clr = tmr_cnt_clr;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1 snap();
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 snap();
    @(negedge clk);
    cpu_rd = 1'b0;
    s_rv = cpu_rvalid;
    d = cpu_rdata;
    chk(s_rv === 1'b1, "R13 rvalid", 32'(s_rv), 1);
  endtask

  task automatic hin(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    host_in_valid = 1'b1; host_in_idx = p; host_in_data = d;
    @(negedge clk);
    host_in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] pv [4];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tmr_en == 3'b0, "R1 tmr_en", 32'(tmr_en), 0);
    chk(host_out == 32'b0, "R1 host_out", host_out, 0);
    chk(cpu_rvalid == 1'b0, "R1 rvalid", 32'(cpu_rvalid), 0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      rd(16'h00F4 + 16'(p), r);
      chk(r == 8'h00, "R1 mailbox", 32'(r), 0);
    end

    // R12 load boot ROM
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rom_ld_valid = 1'b1; rom_ld_addr = 6'(i); rom_ld_data = rom_val(i);
    end
    @(negedge clk) rom_ld_valid = 1'b0;

    // R5 R6 R12 overlay sweep, overlay on after reset (R1)
    for (int i = 0; i < 64; i++) begin
      wr(16'hFFC0 + 16'(i), shd_val(i));
      chk(!s_req, "R6 rom-region write on RAM port", 32'(s_req), 0);
      rd(16'hFFC0 + 16'(i), r);
      chk(r == rom_val(i), "R12 boot rom read", 32'(r), 32'(rom_val(i)));
    end
    wr(16'h00F1, 8'h00);
    for (int i = 0; i < 64; i++) begin
      rd(16'hFFC0 + 16'(i), r);
      chk(r == shd_val(i), "R5 shadow read", 32'(r), 32'(shd_val(i)));
    end
    wr(16'h00F1, 8'h80);
    for (int i = 0; i < 64; i++) wr(16'hFFC0 + 16'(i), ~shd_val(i));
    rd(16'hFFC5, r);
    chk(r == rom_val(5), "R5 overlay on", 32'(r), 32'(rom_val(5)));
    wr(16'h00F1, 8'h00);
    for (int i = 0; i < 64; i++) begin
      rd(16'hFFC0 + 16'(i), r);
      chk(r == ~shd_val(i), "R6 shadow written under overlay", 32'(r), 32'(~shd_val(i)));
    end

    // R2 pass-through sweep
    for (int a = 0; a < 16'h00F0 + 7; a++) begin
      logic [15:0] ad;
      if (a < 16'h00F0) ad = 16'(a);
      else case (a - 16'h00F0)
        0: ad = 16'h00F8; 1: ad = 16'h00F9; 2: ad = 16'h0100; 3: ad = 16'h8000;
        4: ad = 16'hFFBF; 5: ad = 16'h00EF; default: ad = 16'h1234;
      endcase
      wr(ad, ad[7:0] ^ 8'h77);
      chk(s_req && s_we && s_addr == ad && s_wd == (ad[7:0] ^ 8'h77), "R2 write pass",
          {s_req, s_we, 6'b0, s_wd, s_addr}, {2'b11, 6'b0, ad[7:0] ^ 8'h77, ad});
      rd(ad, r);
      chk(s_req && !s_we, "R2 read request", {s_req, s_we}, 2'b10);
      chk(r == ext_val(ad), "R2 read data", 32'(r), 32'(ext_val(ad)));
    end

    // R3 R4 R5 control sweep
    for (int v = 0; v < 256; v++) begin
      for (int p = 0; p < 4; p++) begin
        pv[p] = 8'(v + 16*p) | 8'h80;
        hin(2'(p), pv[p]);
      end
      wr(16'h00F1, 8'(v));
      chk(tmr_en == 3'(v), "R3 timer enables", 32'(tmr_en), 32'(v & 7));
      for (int p = 0; p < 4; p++) begin
        logic [7:0] e;
        e = ((p < 2 && v[4]) || (p >= 2 && v[5])) ? 8'h00 : pv[p];
        rd(16'h00F4 + 16'(p), r);
        chk(r == e, "R4 port clear", 32'(r), 32'(e));
      end
      rd(16'hFFC0 + 16'(v % 64), r);
      chk(r == (v[7] ? rom_val(v % 64) : ~shd_val(v % 64)), "R5 overlay select",
          32'(r), 32'(v[7] ? rom_val(v % 64) : ~shd_val(v % 64)));
    end

    // R4 clear wins over a same-cycle host beat
    hin(2'd1, 8'h5E);
    @(negedge clk);
    host_in_valid = 1'b1; host_in_idx = 2'd0; host_in_data = 8'h99;
    cpu_addr = 16'h00F1; cpu_wdata = 8'h10; cpu_wr = 1'b1;
    @(negedge clk);
    host_in_valid = 1'b0; cpu_wr = 1'b0;
    rd(16'h00F4, r);
    chk(r == 8'h00, "R4 clear beats host beat", 32'(r), 0);
    rd(16'h00F5, r);
    chk(r == 8'h00, "R4 clear port1", 32'(r), 0);

    // R7 R8 DSP index sweep
    for (int k = 0; k < 256; k++) begin
      wr(16'h00F2, 8'(k));
      rd(16'h00F2, r);
      chk(r == 8'(k), "R7 index readback", 32'(r), 32'(k));
      wr(16'h00F3, 8'(k) ^ 8'hF0);
      chk(s_dwr == (k < 128) && !s_req, "R8 dsp write gate", 32'(s_dwr), 32'(k < 128));
      if (k < 128)
        chk(s_da == 7'(k) && s_dwd == (8'(k) ^ 8'hF0), "R8 dsp write fields",
            {s_da, s_dwd}, {7'(k), 8'(k) ^ 8'hF0});
      rd(16'h00F3, r);
      chk(s_drd && s_da == 7'(k), "R7 dsp read request", {s_drd, s_da}, {1'b1, 7'(k)});
      chk(r == dsp_val(7'(k)), "R7 dsp read data", 32'(r), 32'(dsp_val(7'(k))));
    end

    // R9 timers and zero-reading registers
    for (int t = 0; t < 3; t++) begin
      logic [7:0] ec;
      wr(16'h00FA + 16'(t), 8'h30 + 8'(t));
      chk(s_per == 3'(1 << t) && s_pdata == 8'h30 + 8'(t) && s_clr == 0,
          "R9 period strobe", {s_per, s_pdata}, {3'(1 << t), 8'h30 + 8'(t)});
      rd(16'h00FA + 16'(t), r);
      chk(r == 8'h00, "R9 period reads zero", 32'(r), 0);
      ec = 8'(tmr_cnt[4*t +: 4]);
      rd(16'h00FD + 16'(t), r);
      chk(r == ec && s_crd == 3'(1 << t) && s_clr == 0, "R9 counter read",
          {s_crd, r}, {3'(1 << t), ec});
      wr(16'h00FD + 16'(t), 8'hFF);
      chk(s_clr == 3'(1 << t) && s_crd == 0 && s_per == 0, "R9 counter clear",
          32'(s_clr), 32'(1 << t));
    end
    rd(16'h00F0, r);
    chk(r == 8'h00, "R9 F0 reads zero", 32'(r), 0);
    rd(16'h00F1, r);
    chk(r == 8'h00, "R9 F1 reads zero", 32'(r), 0);

    // R11 host output ports
    wr(16'h00F1, 8'h85);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] eo;
      eo = host_out;
      eo[8*p +: 8] = 8'hC0 + 8'(p);
      wr(16'h00F4 + 16'(p), 8'hC0 + 8'(p));
      chk(host_out == eo && !s_req, "R11 host output byte", host_out, eo);
    end
    hin(2'd2, 8'h6B);
    wr(16'h00F6, 8'h11);
    rd(16'h00F6, r);
    chk(r == 8'h6B, "R11 port read returns host input", 32'(r), 32'h6B);

    // R10 test register write is inert
    begin
      logic [31:0] ho;
      ho = host_out;
      wr(16'h00F0, 8'hFF);
      chk(!s_req && !s_dwr && s_per == 0 && s_clr == 0 && s_crd == 0, "R10 no strobes",
          {s_req, s_dwr, s_per, s_clr}, 0);
      chk(tmr_en == 3'b101 && host_out == ho, "R10 state unchanged",
          {tmr_en, host_out[27:0]}, {3'b101, ho[27:0]});
      rd(16'hFFC3, r);
      chk(r == rom_val(3), "R10 overlay unchanged", 32'(r), 32'(rom_val(3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule